// File: doc/BRIEF.md
# Masked Serial-Port Interrupt Requester

This block turns the status flags of a serial remote-control port into one processor interrupt. It has two sources. The receive-ready flag says that a byte from the remote controller is waiting. The transmit-empty flag says that the port can take a byte. The transmit flag counts only after the remote side has asked for status. Two CPU-written enable bits gate each source on its own.

A request that passes its enable bit is caught in a single pending flop. The flop can be set only in the clock cycle where the bus control strobe is high and the bus control code equals a parameterised capture code. The flop clears when the strobe carries the acknowledge code, or on reset. A high interrupt-block line from the CPU forces both outputs inactive. The CPU holds that line high for its whole service routine, so no second request is issued until the routine ends.

The pending state drives an active-low interrupt request. It also drives an active-low priority output for the next device in a chain, which asserts only while the priority input is also asserted. The raw receive-ready flag is brought out as a status bit, so the handler can tell a receive request from a transmit request.

Top module: `serial_irq_requester`

## Requirements
- R1: A clock edge with `rst_n` low clears the pending flop, which leaves `irq_n` and `pri_out_n` both high (inactive) after that edge.
- R2: The receive source counts only while `mask_i[0]` is 1. With `mask_i[0]` at 0, `rx_ready_i` never sets the pending flop.
- R3: The transmit source counts only when `tx_empty_i`, `status_req_i` and `mask_i[1]` are all 1.
- R4: The pending flop is set only at a clock edge where `bus_stb_i` is 1, `bus_code_i` equals CAP_CODE (default 4'hA) and a source counts. A request seen outside such a window is not latched before the next window.
- R5: A clock edge where `bus_stb_i` is 1 and `bus_code_i` equals ACK_CODE (default 4'h5) clears the pending flop. This holds whatever the level of `block_i`.
- R6: Once set, the pending flop stays set when the sources drop or the enable bits change, until an acknowledge or a reset.
- R7: While `block_i` is 1, `irq_n` and `pri_out_n` are both 1.
- R8: While the flop is pending and `block_i` is 0, `irq_n` is 0. `pri_out_n` is 0 only if `pri_in_n` is also 0.
- R9: `rx_status_o` always follows `rx_ready_i`, whatever the enable bits and the pending state.
- R10: When both sources count in one capture window, a single request is latched and `rx_status_o` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_ready_i | input | 1 | Receive data ready flag from the UART |
| tx_empty_i | input | 1 | Transmit buffer empty flag from the UART |
| status_req_i | input | 1 | Remote side has asked for status |
| mask_i | input | 2 | Source enables: bit 0 receive, bit 1 transmit |
| bus_stb_i | input | 1 | Bus control code strobe |
| bus_code_i | input | CODE_W | Bus control code |
| block_i | input | 1 | CPU interrupt-block line, high blocks |
| pri_in_n | input | 1 | Daisy-chain priority input, active low |
| irq_n | output | 1 | Interrupt request to the CPU, active low |
| pri_out_n | output | 1 | Daisy-chain priority output, active low |
| rx_status_o | output | 1 | Receive-source status bit for the handler |

## Verification
The bench shows a request that has passed its enable bit in several wrong cycles: without the strobe, and with the strobe carrying a code other than the capture code. A design that latched on any strobe, or on any code, would pull `irq_n` low too early. It then drops the sources and the enable bits while a request is pending. A flop that followed its input instead of holding would release the request before the handler acknowledged it. The bench raises the block line, and also sends an acknowledge while the line is high. This catches gating that leaks through the block line, or a clear that is lost while the block line is high. It also drives the priority input high with a request pending, and asserts reset while a request is pending.

// File: rtl/serial_irq_pkg.sv
// Shared types for the serial-port interrupt requester.
package serial_irq_pkg;
    // Decoded bus-cycle events, one cycle wide each.
    typedef struct packed {
        logic capture;
        logic ack;
    } bus_evt_t;
endpackage

// File: rtl/irq_source_mask.sv
// Combines the two port flags with the CPU enable bits.
// Assumes: mask bit 0 enables receive, bit 1 enables transmit;
// the transmit flag is meaningful only after a status request.
module irq_source_mask (
    input  logic       rx_ready_i,
    input  logic       tx_empty_i,
    input  logic       status_req_i,
    input  logic [1:0] mask_i,
    output logic       req_o
);
    logic rx_ok;
    logic tx_ok;

    // Qualify each source by its enable bit and merge them.
    always_comb begin
        rx_ok = rx_ready_i & mask_i[0];
        tx_ok = tx_empty_i & status_req_i & mask_i[1];
        req_o = rx_ok | tx_ok;
    end
endmodule

// File: rtl/bus_cycle_decode.sv
// Decodes the bus control code into capture and acknowledge events.
// Assumes: the code is valid only while the strobe is high, and the
// two codes differ.
module bus_cycle_decode
    import serial_irq_pkg::*;
#(
    parameter int              CODE_W   = 4,
    parameter logic [CODE_W-1:0] CAP_CODE = 4'hA,
    parameter logic [CODE_W-1:0] ACK_CODE = 4'h5
) (
    input  logic              bus_stb_i,
    input  logic [CODE_W-1:0] bus_code_i,
    output bus_evt_t          evt_o
);
    // Match the strobed code against the two configured values.
    always_comb begin
        evt_o.capture = bus_stb_i && (bus_code_i == CAP_CODE);
        evt_o.ack     = bus_stb_i && (bus_code_i == ACK_CODE);
    end

    // The codes must differ so a cycle cannot be both events.
    initial begin
        codes_distinct_chk: assert (CAP_CODE != ACK_CODE);
    end
endmodule

// File: rtl/irq_pending_latch.sv
// Holds one pending request, set in capture windows, cleared by acknowledge.
// Assumes: synchronous active-low reset; acknowledge wins over capture.
module irq_pending_latch
    import serial_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_i,
    input  bus_evt_t evt_i,
    output logic     pend_o
);
    // Set on a qualified capture, clear on acknowledge or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_o <= 1'b0;
        else if (evt_i.ack)
            pend_o <= 1'b0;
        else if (evt_i.capture && req_i)
            pend_o <= 1'b1;
    end

    // R4
    set_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_o) |-> $past(evt_i.capture && req_i));

    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i.ack |=> !pend_o);

    // R6
    pend_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o && !evt_i.ack |=> pend_o);
endmodule

// File: rtl/irq_output_gate.sv
// Gates the pending request with the block line and the priority input.
// Assumes: all chain and request pins are active low.
module irq_output_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    input  logic block_i,
    input  logic pri_in_n,
    output logic irq_n,
    output logic pri_out_n
);
    logic live;

    // Drive the request and the chain output from the unblocked request.
    always_comb begin
        live      = pend_i & ~block_i;
        irq_n     = ~live;
        pri_out_n = ~(live & ~pri_in_n);
    end

    // R7
    block_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        block_i |-> (irq_n && pri_out_n));

    // R8
    chain_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pri_out_n |-> (!irq_n && !pri_in_n));
endmodule

// File: rtl/serial_irq_requester.sv
// Top: masked, bus-cycle-timed interrupt requester for a serial port.
// Assumes: one clock domain; bus code and strobe are synchronous to clk.
module serial_irq_requester
    import serial_irq_pkg::*;
#(
    parameter int              CODE_W   = 4,
    parameter logic [CODE_W-1:0] CAP_CODE = 4'hA,
    parameter logic [CODE_W-1:0] ACK_CODE = 4'h5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_ready_i,
    input  logic              tx_empty_i,
    input  logic              status_req_i,
    input  logic [1:0]        mask_i,
    input  logic              bus_stb_i,
    input  logic [CODE_W-1:0] bus_code_i,
    input  logic              block_i,
    input  logic              pri_in_n,
    output logic              irq_n,
    output logic              pri_out_n,
    output logic              rx_status_o
);
    logic     req;
    logic     pend;
    bus_evt_t evt;

    irq_source_mask src_i (
        .rx_ready_i  (rx_ready_i),
        .tx_empty_i  (tx_empty_i),
        .status_req_i(status_req_i),
        .mask_i      (mask_i),
        .req_o       (req)
    );

    bus_cycle_decode #(
        .CODE_W  (CODE_W),
        .CAP_CODE(CAP_CODE),
        .ACK_CODE(ACK_CODE)
    ) dec_i (
        .bus_stb_i (bus_stb_i),
        .bus_code_i(bus_code_i),
        .evt_o     (evt)
    );

    irq_pending_latch lat_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req),
        .evt_i (evt),
        .pend_o(pend)
    );

    irq_output_gate gate_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_i   (pend),
        .block_i  (block_i),
        .pri_in_n (pri_in_n),
        .irq_n    (irq_n),
        .pri_out_n(pri_out_n)
    );

    // Status bit for the handler: the raw receive flag.
    always_comb rx_status_o = rx_ready_i;

    // R2
    rx_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past((rx_ready_i && mask_i[0]) ||
                              (tx_empty_i && status_req_i && mask_i[1])));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (irq_n && pri_out_n));
endmodule

// File: tb/serial_irq_requester_tb.sv
module serial_irq_requester_tb_top;
    localparam int CW = 4;
    localparam logic [3:0] CAP = 4'hA;
    localparam logic [3:0] ACK = 4'h5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_ready_i = 1'b0, tx_empty_i = 1'b0, status_req_i = 1'b0;
    logic [1:0]    mask_i = 2'b00;
    logic          bus_stb_i = 1'b0;
    logic [CW-1:0] bus_code_i = '0;
    logic          block_i = 1'b0, pri_in_n = 1'b0;
    logic          irq_n, pri_out_n, rx_status_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    serial_irq_requester #(.CODE_W(CW), .CAP_CODE(CAP), .ACK_CODE(ACK)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_ready_i(rx_ready_i), .tx_empty_i(tx_empty_i),
        .status_req_i(status_req_i), .mask_i(mask_i), .bus_stb_i(bus_stb_i),
        .bus_code_i(bus_code_i), .block_i(block_i), .pri_in_n(pri_in_n),
        .irq_n(irq_n), .pri_out_n(pri_out_n), .rx_status_o(rx_status_o)
    );

    // Vector: rx tx st mask[2] stb code[4] blk pin eirq epri tag[4]
    localparam int NV = 16;
    localparam logic [21:0] VEC [NV] = '{
        {1'b1,1'b0,1'b0,2'b00,1'b1,4'hA,1'b0,1'b0,1'b1,1'b1,4'd2},  // R2 receive masked
        {1'b0,1'b1,1'b0,2'b11,1'b1,4'hA,1'b0,1'b0,1'b1,1'b1,4'd3},  // R3 no status request
        {1'b0,1'b1,1'b1,2'b01,1'b1,4'hA,1'b0,1'b0,1'b1,1'b1,4'd3},  // R3 transmit disabled
        {1'b1,1'b0,1'b0,2'b01,1'b1,4'h3,1'b0,1'b0,1'b1,1'b1,4'd4},  // R4 wrong code
        {1'b1,1'b0,1'b0,2'b01,1'b0,4'hA,1'b0,1'b0,1'b1,1'b1,4'd4},  // R4 no strobe
        {1'b1,1'b0,1'b0,2'b01,1'b1,4'hA,1'b0,1'b0,1'b0,1'b0,4'd4},  // R4 capture
        {1'b0,1'b0,1'b0,2'b00,1'b0,4'h0,1'b0,1'b0,1'b0,1'b0,4'd6},  // R6 hold
        {1'b0,1'b0,1'b0,2'b00,1'b1,4'hA,1'b0,1'b0,1'b0,1'b0,4'd6},  // R6 window, no source
        {1'b0,1'b0,1'b0,2'b00,1'b0,4'h0,1'b1,1'b0,1'b1,1'b1,4'd7},  // R7 blocked
        {1'b0,1'b0,1'b0,2'b00,1'b0,4'h0,1'b0,1'b1,1'b0,1'b1,4'd8},  // R8 chain not granted
        {1'b0,1'b0,1'b0,2'b00,1'b1,4'h5,1'b0,1'b0,1'b1,1'b1,4'd5},  // R5 acknowledge
        {1'b0,1'b1,1'b1,2'b10,1'b1,4'hA,1'b0,1'b0,1'b0,1'b0,4'd3},  // R3 transmit latched
        {1'b0,1'b0,1'b0,2'b00,1'b1,4'h5,1'b1,1'b0,1'b1,1'b1,4'd5},  // R5 ack while blocked
        {1'b0,1'b0,1'b0,2'b00,1'b0,4'h0,1'b0,1'b0,1'b1,1'b1,4'd5},  // R5 stays clear
        {1'b1,1'b1,1'b1,2'b11,1'b1,4'hA,1'b0,1'b0,1'b0,1'b0,4'd10}, // R10 both sources
        {1'b1,1'b1,1'b1,2'b11,1'b1,4'h5,1'b0,1'b0,1'b1,1'b1,4'd10}  // R10 single ack clears
    };

    task automatic check(input logic act_irq, input logic act_pri, input logic exp_irq,
                         input logic exp_pri, input int tag);
        total++;
        if (act_irq !== exp_irq || act_pri !== exp_pri) begin
            bad++;
            $display("FAIL R%0d irq_n/pri_out_n act=%b%b exp=%b%b", tag, act_irq, act_pri,
                     exp_irq, exp_pri);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #100000;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(irq_n, pri_out_n, 1'b1, 1'b1, 1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {rx_ready_i, tx_empty_i, status_req_i, mask_i, bus_stb_i, bus_code_i,
             block_i, pri_in_n} = VEC[i][21:6];
            @(posedge clk);
            #1.25;
            check(irq_n, pri_out_n, VEC[i][5], VEC[i][4], int'(VEC[i][3:0]));
            // R9: status bit mirrors the receive flag
            total++;
            if (rx_status_o !== rx_ready_i) begin
                bad++;
                $display("FAIL R9 rx_status_o act=%b exp=%b", rx_status_o, rx_ready_i);
            end
        end

        // R1: reset while a request is pending
        @(negedge clk);
        {rx_ready_i, mask_i, bus_stb_i, bus_code_i, block_i, pri_in_n} =
            {1'b1, 2'b01, 1'b1, CAP, 1'b0, 1'b0};
        @(posedge clk); #1.25;
        check(irq_n, pri_out_n, 1'b0, 1'b0, 1);
        @(negedge clk);
        {rx_ready_i, bus_stb_i} = 2'b00;
        rst_n = 1'b0;
        @(posedge clk); #1.25;
        check(irq_n, pri_out_n, 1'b1, 1'b1, 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1.25;
        check(irq_n, pri_out_n, 1'b1, 1'b1, 1);

        // R9: status bit with receive disabled
        @(negedge clk);
        {rx_ready_i, mask_i} = {1'b1, 2'b00};
        #1;
        total++;
        if (rx_status_o !== 1'b1) begin
            bad++;
            $display("FAIL R9 rx_status_o act=%b exp=1", rx_status_o);
        end
        finish_run();
    end
endmodule